// File: doc/BRIEF.md
# Keyed Configuration Port with Logical-Device Banking

This block is the configuration front end of a peripheral controller. The host reaches it through two byte-wide locations on a simple bus. The index location is at the base address (`host_port = 0`) and the data location is at base+1 (`host_port = 1`). After reset the port is locked. A fixed unlock byte written twice in a row to the index location opens configuration mode. A separate lock byte closes it again.

While the port is open, an index write selects a register and a data access reads or writes that register. Registers below 0x30 are global. They hold the logical-device number, the chip identity, the revision and the manufacturer identity. Registers from 0x30 upward belong to the logical device whose number is currently selected: an enable bit, a 16-bit I/O base and a forwarded window. Accesses at or above `EXT_BASE` are not stored here. They are handed to the attached logical device through read/write strobes, together with the register index, the write byte and a returned read byte. The selected device number and the per-device enable bits are driven as outputs.

Top module: `sio_config_port`

## Requirements
- R1: Two consecutive index-port writes of 0x87 while locked set `cfg_mode` on the edge of the second write. A single 0x87 does not unlock.
- R2: While locked, any index-port write other than 0x87 clears a pending first key, so a key byte followed by another byte and then a key byte stays locked.
- R3: While unlocked, an index-port write of 0xAA clears `cfg_mode`. Later data-port writes change no register until the port is unlocked again.
- R4: While locked, a read of either location returns 0xFF and no forwarded strobe is raised. `host_rdata` resets to 0xFF.
- R5: A data write to index 0x07 loads the logical-device number. The number is driven on `ldn` and reads back from 0x07.
- R6: Index 0x20 returns `CHIP_ID[15:8]`, 0x21 returns `CHIP_ID[7:0]` and 0x22 returns `REVISION`. Writes to these registers have no effect.
- R7: Index 0x23 returns 0x19 and index 0x24 returns 0x34.
- R8: Index 0x30 bit 0 is the enable bit of the selected device. It is stored separately per device, driven on `ldn_enable[n]`, and reads back as {7'b0, enable}.
- R9: Index 0x60 (high byte) and 0x61 (low byte) hold the 16-bit I/O base of the selected device, stored separately per device.
- R10: The global registers 0x07 and 0x20–0x24 read the same whatever device number is selected, including numbers with no device.
- R11: A data access at an index of `EXT_BASE` (0x70) or above, with a valid device selected, raises `ext_wr` or `ext_rd` for that cycle with `ext_idx` and `ext_wdata`. A read returns `ext_rdata`.
- R12: Unimplemented indexes read 0xFF. When the selected number is `NUM_LDN` or more, the per-device registers read 0xFF, ignore writes and raise no forwarded strobe.
- R13: Read data appears on `host_rdata` at the clock edge that samples `host_rd` and holds until the next read. An index-port read while unlocked returns the current index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_port | input | 1 | 0 = index location, 1 = data location |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered read byte |
| cfg_mode | output | 1 | Configuration mode is open |
| ldn | output | 8 | Selected logical-device number |
| ldn_enable | output | NUM_LDN | Enable bit of each logical device |
| ext_wr | output | 1 | Forwarded write strobe to the selected device |
| ext_rd | output | 1 | Forwarded read strobe to the selected device |
| ext_idx | output | 8 | Register index of the forwarded access |
| ext_wdata | output | 8 | Write byte of the forwarded access |
| ext_rdata | input | 8 | Read byte returned by the selected device |

## Verification
The bench targets the key sequence first. A model in the bench tracks random index-port traffic that mixes key bytes with other bytes, so a design that unlocks on one key, or that forgets to clear the first key when an unrelated byte follows, shows up as a wrong `cfg_mode`. Banking is exercised with random writes and read-backs across device numbers both inside and outside the implemented range. A shared storage slot, or a write that lands on an out-of-range device, would return another device's enable or base value. The directed cases cover the following faults: data writes that still take effect after the lock byte, identity bytes that are swapped or writable, forwarded strobes that fire for an invalid device, and read data that shifts by a cycle.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam logic [7:0] KEY_OPEN  = 8'h87;
  localparam logic [7:0] KEY_CLOSE = 8'hAA;
  localparam logic [7:0] IDX_LDN   = 8'h07;
  localparam logic [7:0] IDX_ENA   = 8'h30;
  localparam logic [7:0] IDX_BHI   = 8'h60;
  localparam logic [7:0] IDX_BLO   = 8'h61;
  localparam logic [7:0] BYTE_NONE = 8'hFF;

  typedef enum logic [2:0] {
    RC_NONE,
    RC_LDN,
    RC_GLOBAL,
    RC_ENABLE,
    RC_BASE_HI,
    RC_BASE_LO,
    RC_EXT
  } reg_class_e;

  // Sort an index into the register class it addresses.
  function automatic reg_class_e classify(input logic [7:0] idx,
                                          input logic [7:0] ext_base);
    reg_class_e c;
    if (idx == IDX_LDN)                           c = RC_LDN;
    else if (idx >= 8'h20 && idx <= 8'h2F)        c = RC_GLOBAL;
    else if (idx == IDX_ENA)                      c = RC_ENABLE;
    else if (idx == IDX_BHI)                      c = RC_BASE_HI;
    else if (idx == IDX_BLO)                      c = RC_BASE_LO;
    else if (idx >= ext_base)                     c = RC_EXT;
    else                                          c = RC_NONE;
    return c;
  endfunction

  // Identity byte for a global index; unlisted globals read as 0xFF.
  function automatic logic [7:0] ident_byte(input logic [7:0]  idx,
                                            input logic [15:0] chip,
                                            input logic [7:0]  rev,
                                            input logic [15:0] mfg);
    logic [7:0] b;
    case (idx)
      8'h20:   b = chip[15:8];
      8'h21:   b = chip[7:0];
      8'h22:   b = rev;
      8'h23:   b = mfg[15:8];
      8'h24:   b = mfg[7:0];
      default: b = BYTE_NONE;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/sio_key_seq.sv
module sio_key_seq
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       cfg_mode,
  output logic       key_armed
);

  logic mode_q, armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (idx_wr) begin
      if (mode_q) begin
        if (wdata == KEY_CLOSE) mode_q <= 1'b0;
        armed_q <= 1'b0;
      end else if (wdata == KEY_OPEN) begin
        if (armed_q) begin
          mode_q  <= 1'b1;
          armed_q <= 1'b0;
        end else begin
          armed_q <= 1'b1;
        end
      end else begin
        armed_q <= 1'b0;
      end
    end
  end

  assign cfg_mode  = mode_q;
  assign key_armed = armed_q;

endmodule

// File: rtl/sio_global_regs.sv
module sio_global_regs
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] CHIP_ID  = 16'h0A51,
  parameter logic [7:0]  REVISION = 8'h02,
  parameter logic [15:0] MFG_ID   = 16'h1934
) (
  input  logic [7:0] idx,
  output logic [7:0] rd_byte
);

  always_comb rd_byte = ident_byte(idx, CHIP_ID, REVISION, MFG_ID);

endmodule

// File: rtl/sio_ld_bank.sv
module sio_ld_bank #(
  parameter int NUM_LDN = 8,
  localparam int LDN_W  = (NUM_LDN > 1) ? $clog2(NUM_LDN) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_valid,
  input  logic [LDN_W-1:0]   sel,
  input  logic               en_wr,
  input  logic               hi_wr,
  input  logic               lo_wr,
  input  logic [7:0]         wdata,
  output logic               en_rd,
  output logic [15:0]        base_rd,
  output logic [NUM_LDN-1:0] en_vec
);

  logic [15:0] base_q [NUM_LDN];
  logic [NUM_LDN-1:0] en_q;

  for (genvar g = 0; g < NUM_LDN; g++) begin : g_dev
    logic hit;
    assign hit = sel_valid && (sel == LDN_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[g]   <= 1'b0;
        base_q[g] <= 16'h0000;
      end else if (hit) begin
        if (en_wr) en_q[g]         <= wdata[0];
        if (hi_wr) base_q[g][15:8] <= wdata;
        if (lo_wr) base_q[g][7:0]  <= wdata;
      end
    end
  end

  always_comb begin
    en_rd   = 1'b0;
    base_rd = 16'h0000;
    for (int k = 0; k < NUM_LDN; k++) begin
      if (sel_valid && sel == LDN_W'(k)) begin
        en_rd   = en_q[k];
        base_rd = base_q[k];
      end
    end
  end

  assign en_vec = en_q;

endmodule

// File: rtl/sio_config_port.sv
module sio_config_port
  import sio_cfg_pkg::*;
#(
  parameter int          NUM_LDN  = 8,
  parameter logic [7:0]  EXT_BASE = 8'h70,
  parameter logic [15:0] CHIP_ID  = 16'h0A51,
  parameter logic [7:0]  REVISION = 8'h02,
  parameter logic [15:0] MFG_ID   = 16'h1934
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic               host_port,
  input  logic [7:0]         host_wdata,
  output logic [7:0]         host_rdata,
  output logic               cfg_mode,
  output logic [7:0]         ldn,
  output logic [NUM_LDN-1:0] ldn_enable,
  output logic               ext_wr,
  output logic               ext_rd,
  output logic [7:0]         ext_idx,
  output logic [7:0]         ext_wdata,
  input  logic [7:0]         ext_rdata
);

  localparam int         LDN_W     = (NUM_LDN > 1) ? $clog2(NUM_LDN) : 1;
  localparam logic [8:0] LDN_LIMIT = 9'(NUM_LDN);

  // Named internal events
  logic       idx_wr, data_wr, data_rd, key_armed, ldn_valid;
  logic [7:0] idx_q, ldn_q, glob_byte, rd_next, rdata_q;
  logic       bank_en;
  logic [15:0] bank_base;
  reg_class_e cls;

  assign idx_wr  = host_wr && !host_port;
  assign data_wr = host_wr &&  host_port && cfg_mode;
  assign data_rd = host_rd &&  host_port && cfg_mode;

  sio_key_seq u_key (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx_wr    (idx_wr),
    .wdata     (host_wdata),
    .cfg_mode  (cfg_mode),
    .key_armed (key_armed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                          idx_q <= 8'h00;
    else if (idx_wr && cfg_mode && host_wdata != KEY_CLOSE) idx_q <= host_wdata;
  end

  assign cls = classify(idx_q, EXT_BASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ldn_q <= 8'h00;
    else if (data_wr && cls == RC_LDN)   ldn_q <= host_wdata;
  end

  assign ldn_valid = ({1'b0, ldn_q} < LDN_LIMIT);

  sio_global_regs #(
    .CHIP_ID  (CHIP_ID),
    .REVISION (REVISION),
    .MFG_ID   (MFG_ID)
  ) u_glob (
    .idx     (idx_q),
    .rd_byte (glob_byte)
  );

  sio_ld_bank #(.NUM_LDN(NUM_LDN)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_valid (ldn_valid),
    .sel       (ldn_q[LDN_W-1:0]),
    .en_wr     (data_wr && cls == RC_ENABLE),
    .hi_wr     (data_wr && cls == RC_BASE_HI),
    .lo_wr     (data_wr && cls == RC_BASE_LO),
    .wdata     (host_wdata),
    .en_rd     (bank_en),
    .base_rd   (bank_base),
    .en_vec    (ldn_enable)
  );

  assign ext_wr    = data_wr && cls == RC_EXT && ldn_valid;
  assign ext_rd    = data_rd && cls == RC_EXT && ldn_valid;
  assign ext_idx   = idx_q;
  assign ext_wdata = host_wdata;

  always_comb begin
    rd_next = BYTE_NONE;
    if (cfg_mode) begin
      if (!host_port) begin
        rd_next = idx_q;
      end else begin
        case (cls)
          RC_LDN:     rd_next = ldn_q;
          RC_GLOBAL:  rd_next = glob_byte;
          RC_ENABLE:  rd_next = ldn_valid ? {7'b0, bank_en} : BYTE_NONE;
          RC_BASE_HI: rd_next = ldn_valid ? bank_base[15:8] : BYTE_NONE;
          RC_BASE_LO: rd_next = ldn_valid ? bank_base[7:0]  : BYTE_NONE;
          RC_EXT:     rd_next = ldn_valid ? ext_rdata       : BYTE_NONE;
          default:    rd_next = BYTE_NONE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= BYTE_NONE;
    else if (host_rd) rdata_q <= rd_next;
  end

  assign host_rdata = rdata_q;
  assign ldn        = ldn_q;

endmodule

// File: rtl/sio_config_port_chk.sv
module sio_config_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_wr,
  input logic       host_rd,
  input logic       host_port,
  input logic [7:0] host_wdata,
  input logic [7:0] host_rdata,
  input logic       cfg_mode,
  input logic [7:0] ldn,
  input logic       ext_wr,
  input logic       ext_rd,
  input logic [7:0] ext_idx,
  input logic [7:0] ext_base,
  input logic [7:0] cur_idx,
  input logic       key_armed
);

  a_r1_open_needs_second_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_mode) |-> $past(key_armed && host_wr && !host_port && host_wdata == 8'h87));

  a_r3_close_key_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && host_wr && !host_port && host_wdata == 8'hAA) |=> !cfg_mode);

  a_r4_locked_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode && host_rd) |=> host_rdata == 8'hFF);

  a_r4_locked_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |-> !(ext_wr || ext_rd));

  a_r5_ldn_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_mode && host_wr && host_port && cur_idx == 8'h07) |=> $stable(ldn));

  a_r11_strobe_window: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_wr || ext_rd) |-> (ext_idx >= ext_base && $onehot0({ext_wr, ext_rd})));

  a_r13_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(host_rdata));

endmodule

bind sio_config_port sio_config_port_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .host_port  (host_port),
  .host_wdata (host_wdata),
  .host_rdata (host_rdata),
  .cfg_mode   (cfg_mode),
  .ldn        (ldn),
  .ext_wr     (ext_wr),
  .ext_rd     (ext_rd),
  .ext_idx    (ext_idx),
  .ext_base   (EXT_BASE),
  .cur_idx    (idx_q),
  .key_armed  (key_armed)
);

// File: tb/test_sio_config_port.sv
`timescale 1ns/1ps
module test_sio_config_port;

  localparam int NDEV = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 1'b0, host_rd = 1'b0, host_port = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic cfg_mode;
  logic [7:0] ldn;
  logic [NDEV-1:0] ldn_enable;
  logic ext_wr, ext_rd;
  logic [7:0] ext_idx, ext_wdata, ext_rdata;

  int compared = 0, mismatched = 0;
  int ext_wr_cnt = 0, ext_rd_cnt = 0;
  logic [7:0] last_ext_idx = 8'h00, last_ext_data = 8'h00;

  always #2 clk = ~clk;

  assign ext_rdata = ext_idx ^ 8'hC3;

  always @(posedge clk) begin
    if (ext_wr) begin
      ext_wr_cnt    <= ext_wr_cnt + 1;
      last_ext_idx  <= ext_idx;
      last_ext_data <= ext_wdata;
    end
    if (ext_rd) ext_rd_cnt <= ext_rd_cnt + 1;
  end

  sio_config_port #(.NUM_LDN(NDEV)) i_sio_config_port (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_port(host_port), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cfg_mode(cfg_mode), .ldn(ldn), .ldn_enable(ldn_enable),
    .ext_wr(ext_wr), .ext_rd(ext_rd), .ext_idx(ext_idx),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic port, input logic [7:0] d);
    @(negedge clk);
    host_port = port; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic port, output logic [7:0] d);
    @(negedge clk);
    host_port = port; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic reg_wr(input logic [7:0] idx, input logic [7:0] d);
    wr(1'b0, idx); wr(1'b1, d);
  endtask

  task automatic reg_rd(input logic [7:0] idx, output logic [7:0] d);
    wr(1'b0, idx); rd(1'b1, d);
  endtask

  task automatic unlock();
    wr(1'b0, 8'h87); wr(1'b0, 8'h87);
  endtask

  // Bench-side expectations
  function automatic logic [7:0] exp_ident(input logic [7:0] idx);
    case (idx)
      8'h20: return 8'h0A;
      8'h21: return 8'h51;
      8'h22: return 8'h02;
      8'h23: return 8'h19;
      8'h24: return 8'h34;
      default: return 8'hFF;
    endcase
  endfunction

  logic        m_en   [10];
  logic [15:0] m_base [10];

  initial begin
    #(4 * 200000);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic mode_m, armed_m;
    int wr_before;
    process::self().srandom(32'd7781);
    for (int i = 0; i < 10; i++) begin m_en[i] = 1'b0; m_base[i] = 16'h0; end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4 reset rdata", {8'h0, host_rdata}, 16'h00FF);
    chk("R1 reset locked", {15'h0, cfg_mode}, 16'h0);
    chk("R5 reset ldn", {8'h0, ldn}, 16'h0);
    chk("R8 reset enables", {8'h0, ldn_enable}, 16'h0);

    // Locked accesses
    rd(1'b1, r); chk("R4 locked data read", {8'h0, r}, 16'h00FF);
    rd(1'b0, r); chk("R4 locked index read", {8'h0, r}, 16'h00FF);
    wr(1'b0, 8'h07); wr(1'b1, 8'h05);
    chk("R3 locked write ignored", {8'h0, ldn}, 16'h0);

    // Key sequence corners
    wr(1'b0, 8'h87);
    chk("R1 single key", {15'h0, cfg_mode}, 16'h0);
    wr(1'b0, 8'h55); wr(1'b0, 8'h87);
    chk("R2 broken key pair", {15'h0, cfg_mode}, 16'h0);
    wr(1'b0, 8'h87);
    chk("R1 key pair opens", {15'h0, cfg_mode}, 16'h1);

    // Identity registers
    for (int a = 8'h20; a <= 8'h24; a++) begin
      reg_rd(8'(a), r);
      chk((a < 8'h23) ? "R6 ident" : "R7 mfg id", {8'h0, r}, {8'h0, exp_ident(8'(a))});
    end
    reg_wr(8'h21, 8'h00); reg_rd(8'h21, r);
    chk("R6 write ignored", {8'h0, r}, 16'h0051);

    // Device select
    reg_wr(8'h07, 8'h03);
    chk("R5 ldn port", {8'h0, ldn}, 16'h0003);
    reg_rd(8'h07, r); chk("R5 ldn readback", {8'h0, r}, 16'h0003);

    // Enable and base
    reg_wr(8'h30, 8'h01);
    chk("R8 enable out", {8'h0, ldn_enable}, 16'h0008);
    reg_rd(8'h30, r); chk("R8 enable read", {8'h0, r}, 16'h0001);
    reg_wr(8'h30, 8'hFE);
    chk("R8 enable clear", {8'h0, ldn_enable}, 16'h0000);
    reg_wr(8'h60, 8'h02); reg_wr(8'h61, 8'hE8);
    reg_rd(8'h60, r); chk("R9 base hi", {8'h0, r}, 16'h0002);
    reg_rd(8'h61, r); chk("R9 base lo", {8'h0, r}, 16'h00E8);
    m_base[3] = 16'h02E8;

    // Out-of-range device
    reg_wr(8'h07, 8'h09);
    reg_rd(8'h22, r); chk("R10 global with bad ldn", {8'h0, r}, 16'h0002);
    reg_rd(8'h07, r); chk("R10 ldn read with bad ldn", {8'h0, r}, 16'h0009);
    reg_rd(8'h30, r); chk("R12 bad ldn enable", {8'h0, r}, 16'h00FF);
    reg_wr(8'h30, 8'h01);
    chk("R12 bad ldn write ignored", {8'h0, ldn_enable}, 16'h0000);
    wr_before = ext_wr_cnt;
    reg_wr(8'h75, 8'h11);
    chk("R12 bad ldn no strobe", 16'(ext_wr_cnt), 16'(wr_before));
    reg_rd(8'h40, r); chk("R12 unimplemented", {8'h0, r}, 16'h00FF);

    // Forwarded window
    reg_wr(8'h07, 8'h02);
    reg_wr(8'h75, 8'h3C);
    chk("R11 ext write count", 16'(ext_wr_cnt), 16'(wr_before + 1));
    chk("R11 ext write idx/data", {last_ext_idx, last_ext_data}, 16'h753C);
    reg_rd(8'h80, r); chk("R11 ext read", {8'h0, r}, {8'h0, 8'h80 ^ 8'hC3});
    chk("R11 ext read count", 16'(ext_rd_cnt), 16'h0001);

    // Read timing and index read
    wr(1'b0, 8'h5B); rd(1'b0, r);
    chk("R13 index read", {8'h0, r}, 16'h005B);
    wr(1'b0, 8'h22);
    chk("R13 rdata holds", {8'h0, host_rdata}, 16'h005B);

    // Random banking
    for (int n = 0; n < 300; n++) begin
      int dv, op;
      logic [7:0] val;
      dv = $urandom_range(0, 9); op = $urandom_range(0, 5); val = 8'($urandom);
      reg_wr(8'h07, 8'(dv));
      case (op)
        0: begin reg_wr(8'h30, val); if (dv < NDEV) m_en[dv] = val[0]; end
        1: begin reg_wr(8'h60, val); if (dv < NDEV) m_base[dv][15:8] = val; end
        2: begin reg_wr(8'h61, val); if (dv < NDEV) m_base[dv][7:0] = val; end
        3: begin reg_rd(8'h30, r);
           chk("R8 random enable", {8'h0, r}, {8'h0, (dv < NDEV) ? {7'b0, m_en[dv]} : 8'hFF}); end
        4: begin reg_rd(8'h60, r);
           chk("R9 random base hi", {8'h0, r}, {8'h0, (dv < NDEV) ? m_base[dv][15:8] : 8'hFF}); end
        default: begin reg_rd(8'h61, r);
           chk("R9 random base lo", {8'h0, r}, {8'h0, (dv < NDEV) ? m_base[dv][7:0] : 8'hFF}); end
      endcase
    end
    begin
      logic [NDEV-1:0] ev;
      for (int i = 0; i < NDEV; i++) ev[i] = m_en[i];
      chk("R8 enable vector", {8'h0, ldn_enable}, {8'h0, ev});
    end

    // Lock and ignore
    reg_wr(8'h07, 8'h04);
    wr(1'b0, 8'hAA);
    chk("R3 close key", {15'h0, cfg_mode}, 16'h0);
    wr(1'b0, 8'h07); wr(1'b1, 8'h06);
    chk("R3 write after lock", {8'h0, ldn}, 16'h0004);
    rd(1'b1, r); chk("R4 read after lock", {8'h0, r}, 16'h00FF);
    unlock();
    reg_rd(8'h07, r); chk("R3 ldn kept", {8'h0, r}, 16'h0004);

    // Random key traffic with a bench model
    mode_m = 1'b1; armed_m = 1'b0;
    for (int n = 0; n < 400; n++) begin
      logic [7:0] b;
      int pick;
      pick = $urandom_range(0, 9);
      b = (pick < 5) ? 8'h87 : (pick == 5) ? 8'hAA : 8'($urandom);
      wr(1'b0, b);
      if (mode_m) begin
        if (b == 8'hAA) mode_m = 1'b0;
        armed_m = 1'b0;
      end else if (b == 8'h87) begin
        if (armed_m) begin mode_m = 1'b1; armed_m = 1'b0; end
        else armed_m = 1'b1;
      end else armed_m = 1'b0;
      if (n % 20 == 0 || cfg_mode !== mode_m)
        chk("R2 random key stream", {15'h0, cfg_mode}, {15'h0, mode_m});
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule